// File: doc/BRIEF.md
# Segmented Degamma Lookup Table

This block linearises one colour channel of a display pipe before the colour-space matrix stage. Each pixel arrives as an unsigned fixed-point value with three integer bits and sixteen fractional bits. The block looks the value up in a 35-entry table and interpolates linearly between the two neighbouring entries. Entries 0 to 32 cover the range 0 to just below 1.0 in 32 equal segments. Entry 33 is the output for an input of 3.0, and entry 34 is the output for an input of 7.0. Between 1.0 and 7.0 the block interpolates against these two extended points only when the extended-input mode is on. When the degamma enable bit is clear, every pixel passes through unchanged, with the same latency as a looked-up pixel.

A host loads the table through a small register port that has three words. The index word holds the table position and an auto-increment flag. The data word reads or writes the entry at the current position. The mode word holds the enable bit and the extended-input bit. Table writes may happen while pixels are flowing. A pixel presented after a write uses the new value.

Top module: `dgam_top`

## Requirements
- R1: After reset, the index is 0, auto-increment is clear, the mode word reads 0 and out_valid is low. Entry i holds i×2048 for i ≤ 32, entry 33 holds 0x30000 and entry 34 holds 0x70000.
- R2: Register addresses are 0 = index, 1 = data, 2 = mode. A data write stores reg_wdata[18:0] at the current index. A data read returns that entry on reg_rdata in the cycle after reg_re.
- R3: The index word carries the index in bits 5:0 and auto-increment in bit 10. When auto-increment is set, each data write or data read advances the index by one. From 34 the index wraps to 0.
- R4: An index write always updates the auto-increment bit. It loads the index field only if auto-increment was already clear before the write; otherwise the index is unchanged. A field value above 34 loads 0.
- R5: When mode bit 31 (enable) is clear, pix_out equals pix_in.
- R6: Every pixel takes exactly 2 cycles: out_valid follows pix_valid two clocks later, and it is low otherwise.
- R7: For an input below 1.0, let k = x[15:11] and t = x[10:0]·32. The output is e[k] + floor((e[k+1] − e[k])·t / 65536).
- R8: With mode bit 2 (extended) set, the extended points are used:
  - for 1.0 ≤ x < 3.0, the same formula applies with entries 32 and 33 and t = (x − 0x10000) >> 1;
  - for 3.0 ≤ x < 7.0, it applies with entries 33 and 34 and t = (x − 0x30000) >> 2;
  - for x ≥ 7.0, the output is e[34].
- R9: With the extended bit clear and the enable bit set, any input ≥ 1.0 outputs e[32].
- R10: A table write takes effect for a pixel presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 index, 1 data, 2 mode |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read value, valid the cycle after reg_re |
| pix_valid | input | 1 | Pixel present |
| pix_in | input | 19 | Pixel value, 3.16 unsigned |
| out_valid | output | 1 | Result present |
| pix_out | output | 19 | Result, 3.16 unsigned |

## Verification
The bench builds the block with its default parameters: three integer bits, sixteen fractional bits and five segment bits. This gives the 33 + 2 entry layout, so every segment path can be reached with hand-computed values. The reset identity table makes the expected outputs exact for all the bypass, uniform, clamped and extended vectors. Loading non-monotonic entries then exercises the signed interpolation with a falling slope. Placing the index at the last entry brings the wrap and the saturation on entry 34 within reach.

// File: rtl/dgam_pkg.sv
package dgam_pkg;
   typedef enum logic [1:0] {
      RA_INDEX = 2'd0,
      RA_DATA  = 2'd1,
      RA_MODE  = 2'd2,
      RA_NONE  = 2'd3
   } reg_addr_e;

   localparam int AI_BIT  = 10;  // auto-increment flag in index word
   localparam int EN_BIT  = 31;  // degamma enable in mode word
   localparam int EXT_BIT = 2;   // extended-input mode in mode word
endpackage

// File: rtl/dgam_regs.sv
module dgam_regs #(
   parameter int FRAC_W   = 16,
   parameter int INT_W    = 3,
   parameter int SEG_BITS = 5,
   localparam int OUT_W   = FRAC_W + INT_W,
   localparam int NPTS    = (1 << SEG_BITS) + 1,
   localparam int NENT    = NPTS + 2,
   localparam int IDX_W   = $clog2(NENT),
   localparam int WGT_W   = FRAC_W - SEG_BITS
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_we,
   input  logic                           reg_re,
   input  logic [1:0]                     reg_addr,
   input  logic [31:0]                    reg_wdata,
   output logic [31:0]                    reg_rdata,
   output logic [NENT-1:0][OUT_W-1:0]     tbl,
   output logic                           deg_en,
   output logic                           ext_en,
   output logic [IDX_W-1:0]               cur_idx,
   output logic                           auto_inc
);
   import dgam_pkg::*;

   function automatic logic [OUT_W-1:0] init_val(input int e);
      if (e < NPTS)       return OUT_W'(e) << WGT_W;
      else if (e == NPTS) return OUT_W'(3) << FRAC_W;
      else                return OUT_W'(7) << FRAC_W;
   endfunction

   logic                wr_idx, wr_dat, rd_dat, wr_mode;
   logic [IDX_W-1:0]    idx_nxt, idx_fld;

   assign wr_idx  = reg_we && (reg_addr == RA_INDEX);
   assign wr_dat  = reg_we && (reg_addr == RA_DATA);
   assign wr_mode = reg_we && (reg_addr == RA_MODE);
   assign rd_dat  = reg_re && (reg_addr == RA_DATA);
   assign idx_nxt = (cur_idx == IDX_W'(NENT - 1)) ? '0 : cur_idx + 1'b1;
   assign idx_fld = (reg_wdata[IDX_W-1:0] < IDX_W'(NENT)) ? reg_wdata[IDX_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx  <= '0;
         auto_inc <= 1'b0;
      end else if (wr_idx) begin
         auto_inc <= reg_wdata[AI_BIT];
         if (!auto_inc) cur_idx <= idx_fld;
      end else if ((wr_dat || rd_dat) && auto_inc) begin
         cur_idx <= idx_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deg_en <= 1'b0;
         ext_en <= 1'b0;
      end else if (wr_mode) begin
         deg_en <= reg_wdata[EN_BIT];
         ext_en <= reg_wdata[EXT_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++) tbl[e] <= init_val(e);
      end else if (wr_dat) begin
         tbl[cur_idx] <= reg_wdata[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_re) begin
         reg_rdata <= '0;
         case (reg_addr)
            RA_INDEX: begin
               reg_rdata[AI_BIT]      <= auto_inc;
               reg_rdata[IDX_W-1:0]   <= cur_idx;
            end
            RA_DATA:  reg_rdata[OUT_W-1:0] <= tbl[cur_idx];
            RA_MODE: begin
               reg_rdata[EN_BIT]  <= deg_en;
               reg_rdata[EXT_BIT] <= ext_en;
            end
            default:  reg_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/dgam_seg_dec.sv
module dgam_seg_dec #(
   parameter int FRAC_W   = 16,
   parameter int INT_W    = 3,
   parameter int SEG_BITS = 5,
   localparam int OUT_W   = FRAC_W + INT_W,
   localparam int NPTS    = (1 << SEG_BITS) + 1,
   localparam int NENT    = NPTS + 2,
   localparam int IDX_W   = $clog2(NENT),
   localparam int WGT_W   = FRAC_W - SEG_BITS
) (
   input  logic [OUT_W-1:0]  x,
   input  logic              ext_en,
   output logic [IDX_W-1:0]  lo,
   output logic [IDX_W-1:0]  hi,
   output logic [FRAC_W-1:0] t
);
   localparam logic [OUT_W-1:0] ONE   = OUT_W'(1) << FRAC_W;
   localparam logic [OUT_W-1:0] THREE = OUT_W'(3) << FRAC_W;
   localparam logic [OUT_W-1:0] SEVEN = OUT_W'(7) << FRAC_W;
   localparam logic [IDX_W-1:0] I_TOP = IDX_W'(NPTS - 1);
   localparam logic [IDX_W-1:0] I_E3  = IDX_W'(NPTS);
   localparam logic [IDX_W-1:0] I_E7  = IDX_W'(NPTS + 1);

   logic [OUT_W-1:0] off1, off3;
   assign off1 = x - ONE;
   assign off3 = x - THREE;

   always_comb begin
      if (x < ONE) begin
         lo = IDX_W'(x[FRAC_W-1:WGT_W]);
         hi = lo + 1'b1;
         t  = {x[WGT_W-1:0], {SEG_BITS{1'b0}}};
      end else if (!ext_en) begin
         lo = I_TOP;
         hi = I_TOP;
         t  = '0;
      end else if (x < THREE) begin
         lo = I_TOP;
         hi = I_E3;
         t  = off1[FRAC_W:1];
      end else if (x < SEVEN) begin
         lo = I_E3;
         hi = I_E7;
         t  = off3[FRAC_W+1:2];
      end else begin
         lo = I_E7;
         hi = I_E7;
         t  = '0;
      end
   end
endmodule

// File: rtl/dgam_lerp.sv
module dgam_lerp #(
   parameter int FRAC_W = 16,
   parameter int OUT_W  = 19
) (
   input  logic [OUT_W-1:0]  a,
   input  logic [OUT_W-1:0]  b,
   input  logic [FRAC_W-1:0] t,
   output logic [OUT_W-1:0]  y
);
   logic signed [OUT_W:0]          diff;
   logic signed [OUT_W+FRAC_W+1:0] prod;
   logic signed [OUT_W+FRAC_W+1:0] step;
   logic signed [OUT_W+1:0]        sum;

   assign diff = $signed({1'b0, b}) - $signed({1'b0, a});
   assign prod = diff * $signed({1'b0, t});
   assign step = prod >>> FRAC_W;
   assign sum  = $signed({2'b00, a}) + step[OUT_W+1:0];
   assign y    = sum[OUT_W-1:0];
endmodule

// File: rtl/dgam_top.sv
module dgam_top #(
   parameter int FRAC_W   = 16,
   parameter int INT_W    = 3,
   parameter int SEG_BITS = 5,
   localparam int OUT_W   = FRAC_W + INT_W,
   localparam int NPTS    = (1 << SEG_BITS) + 1,
   localparam int NENT    = NPTS + 2,
   localparam int IDX_W   = $clog2(NENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              pix_valid,
   input  logic [OUT_W-1:0]  pix_in,
   output logic              out_valid,
   output logic [OUT_W-1:0]  pix_out
);
   generate
      if (INT_W != 3) begin : g_bad_int
         $error("INT_W must be 3 so that 3.0 and 7.0 are representable");
      end
      if (SEG_BITS < 1 || SEG_BITS >= FRAC_W) begin : g_bad_seg
         $error("SEG_BITS must lie between 1 and FRAC_W-1");
      end
      if (IDX_W > dgam_pkg::AI_BIT) begin : g_bad_idx
         $error("index field overlaps the auto-increment flag");
      end
   endgenerate

   logic [NENT-1:0][OUT_W-1:0] tbl;
   logic                       deg_en, ext_en, auto_inc;
   logic [IDX_W-1:0]           cur_idx;
   logic [IDX_W-1:0]           lo, hi;
   logic [FRAC_W-1:0]          t;
   logic [OUT_W-1:0]           y;

   dgam_regs #(.FRAC_W(FRAC_W), .INT_W(INT_W), .SEG_BITS(SEG_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tbl(tbl), .deg_en(deg_en), .ext_en(ext_en),
      .cur_idx(cur_idx), .auto_inc(auto_inc)
   );

   dgam_seg_dec #(.FRAC_W(FRAC_W), .INT_W(INT_W), .SEG_BITS(SEG_BITS)) u_dec (
      .x(pix_in), .ext_en(ext_en), .lo(lo), .hi(hi), .t(t)
   );

   // stage 1: segment pick and table fetch
   logic              s1_vld, s1_byp;
   logic [OUT_W-1:0]  s1_x, s1_a, s1_b;
   logic [FRAC_W-1:0] s1_t;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_byp <= 1'b1;
         s1_x   <= '0;
         s1_a   <= '0;
         s1_b   <= '0;
         s1_t   <= '0;
      end else begin
         s1_vld <= pix_valid;
         s1_byp <= !deg_en;
         s1_x   <= pix_in;
         s1_a   <= tbl[lo];
         s1_b   <= tbl[hi];
         s1_t   <= t;
      end
   end

   dgam_lerp #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_lerp (
      .a(s1_a), .b(s1_b), .t(s1_t), .y(y)
   );

   // stage 2: interpolate or bypass
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pix_out   <= '0;
      end else begin
         out_valid <= s1_vld;
         pix_out   <= s1_byp ? s1_x : y;
      end
   end
endmodule

// File: rtl/dgam_chk.sv
module dgam_chk #(
   parameter int NENT  = 35,
   parameter int IDX_W = 6,
   parameter int OUT_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic              pix_valid,
   input  logic [OUT_W-1:0]  pix_in,
   input  logic              out_valid,
   input  logic [OUT_W-1:0]  pix_out,
   input  logic [IDX_W-1:0]  cur_idx,
   input  logic              auto_inc,
   input  logic              deg_en
);
   a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      cur_idx < IDX_W'(NENT));

   a_r3_wrap_last: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1 && auto_inc && cur_idx == IDX_W'(NENT - 1))
      |=> (cur_idx == '0));

   a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && auto_inc) |=> (cur_idx == $past(cur_idx)));

   a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !deg_en) |=> ##1 (pix_out == $past(pix_in, 2)));

   a_r6_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> ##1 out_valid);

   a_r6_idle_lat: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ##1 !out_valid);
endmodule

bind dgam_top dgam_chk #(.NENT(NENT), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid),
   .pix_out(pix_out), .cur_idx(cur_idx), .auto_inc(auto_inc), .deg_en(deg_en)
);

// File: tb/dgam_top_tb_top.sv
module dgam_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pix_valid = 1'b0;
   logic [18:0] pix_in = '0;
   logic        out_valid;
   logic [18:0] pix_out;

   int total = 0;
   int bad   = 0;

   localparam logic [31:0] AI = 32'h400;
   localparam logic [31:0] EN = 32'h8000_0000;
   localparam logic [31:0] XT = 32'h4;

   // {enable, extended, input, expected} against the reset identity table
   localparam logic [39:0] VEC [12] = '{
      {1'b1, 1'b0, 19'h00000, 19'h00000},   // R7
      {1'b1, 1'b0, 19'h0ABCD, 19'h0ABCD},   // R7
      {1'b1, 1'b0, 19'h0FFFF, 19'h0FFFF},   // R7
      {1'b1, 1'b0, 19'h12345, 19'h10000},   // R9
      {1'b1, 1'b1, 19'h12345, 19'h12344},   // R8
      {1'b1, 1'b1, 19'h2FFFF, 19'h2FFFE},   // R8
      {1'b1, 1'b1, 19'h30000, 19'h30000},   // R8
      {1'b1, 1'b1, 19'h4567B, 19'h45678},   // R8
      {1'b1, 1'b1, 19'h70000, 19'h70000},   // R8
      {1'b1, 1'b1, 19'h7FFFF, 19'h70000},   // R8
      {1'b0, 1'b0, 19'h7FFFF, 19'h7FFFF},   // R5
      {1'b0, 1'b1, 19'h12345, 19'h12345}    // R5
   };

   dgam_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_valid(pix_valid), .pix_in(pix_in),
      .out_valid(out_valid), .pix_out(pix_out)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
      reg_re = 1'b1; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      reg_re = 1'b0;
   endtask

   task automatic pixel(input string req, input logic [18:0] x, input logic [18:0] exp);
      pix_valid = 1'b1; pix_in = x;
      @(negedge clk);
      pix_valid = 1'b0;
      check({req, " (R6 valid not early)"}, {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      check({req, " (R6 valid)"}, {31'b0, out_valid}, 32'd1);
      check(req, {13'b0, pix_out}, {13'b0, exp});
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 out_valid", {31'b0, out_valid}, 32'd0);
      reg_rd(2'd0, rd); check("R1 index word", rd, 32'd0);
      reg_rd(2'd2, rd); check("R1 mode word", rd, 32'd0);
      reg_wr(2'd0, 32'd5);
      reg_rd(2'd1, rd); check("R1 entry 5", rd, 32'h2800);
      reg_wr(2'd0, 32'd33);
      reg_rd(2'd1, rd); check("R1 entry 33", rd, 32'h30000);
      reg_wr(2'd0, 32'd0);

      // vector walk
      for (int i = 0; i < 12; i++) begin
         reg_wr(2'd2, (VEC[i][39] ? EN : 32'd0) | (VEC[i][38] ? XT : 32'd0));
         pixel($sformatf("vec %0d R5/R7/R8/R9", i), VEC[i][37:19], VEC[i][18:0]);
      end

      // R4 index write rules
      reg_wr(2'd0, AI | 32'd33);
      reg_rd(2'd0, rd); check("R4 load while clear", rd, AI | 32'd33);
      reg_wr(2'd0, 32'd7);
      reg_rd(2'd0, rd); check("R4 index held while set", rd, 32'd33);
      reg_wr(2'd0, 32'd7);
      reg_rd(2'd0, rd); check("R4 load after clear", rd, 32'd7);
      reg_wr(2'd0, 32'd40);
      reg_rd(2'd0, rd); check("R4 out of range loads 0", rd, 32'd0);

      // R3 auto-increment and wrap, R2 write/read
      reg_wr(2'd0, AI | 32'd34);
      reg_wr(2'd1, 32'h11111);
      reg_rd(2'd0, rd); check("R3 wrap to 0", rd, AI);
      reg_wr(2'd1, 32'h22222);
      reg_rd(2'd0, rd); check("R3 advance on write", rd, AI | 32'd1);
      reg_wr(2'd0, 32'd0);
      reg_wr(2'd0, 32'd34);
      reg_rd(2'd1, rd); check("R2 entry 34 readback", rd, 32'h11111);
      reg_wr(2'd0, 32'd0);
      reg_rd(2'd1, rd); check("R2 entry 0 readback", rd, 32'h22222);
      reg_wr(2'd0, AI);
      reg_rd(2'd1, rd); check("R3 read seq 0", rd, 32'h22222);
      reg_rd(2'd1, rd); check("R3 read seq 1", rd, 32'h800);
      reg_rd(2'd0, rd); check("R3 advance on read", rd, AI | 32'd2);

      // R7 falling slope, R8 saturation on loaded entry 34
      reg_wr(2'd2, EN | XT);
      pixel("R7 falling slope", 19'h00400, 19'h11511);
      pixel("R8 saturate to entry 34", 19'h7ABCD, 19'h11111);

      // R10 write then immediate pixel
      pixel("R10 before write", 19'h00800, 19'h00800);
      reg_wr(2'd0, 32'd0);
      reg_wr(2'd0, 32'd1);
      reg_wr(2'd1, 32'h40000);
      pixel("R10 after write", 19'h00800, 19'h40000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule